// File: doc/BRIEF.md
# SPI FIFO Word Packer and Unpacker

This block sits between a host-facing pair of 32-bit FIFOs and a serial shift engine. On the transmit side the host writes 32-bit FIFO words. An unpacking state machine takes them out one at a time and hands them to the engine as individual SPI words of a programmable bit length (4 to 32 bits). On the receive side a packing state machine gathers SPI words from the engine into 32-bit FIFO words. When a command ends part-way through a FIFO word, it commits that word with a last marker and a count of its valid bytes.

Several SPI words share one FIFO word only when the word length divides 32 exactly. For every other length each SPI word gets a FIFO word of its own. The bit order on the wire is selectable. The block drives level status for a transmit low-water mark, a receive high-water mark and a pending final word. It throttles the engine before the receive FIFO can overflow. A flush input returns everything to the empty state.

The transmit machine has two states:
- `TXU_EMPTY` goes to `TXU_SEND` when the FIFO holds a word. It pops that word.
- `TXU_SEND` goes back to `TXU_EMPTY` when the engine accepts the last slot.

The receive machine also has two states:
- `RXP_FILL` goes to `RXP_COMMIT` when it accepts the last slot of a word, or a word flagged as final.
- `RXP_COMMIT` pushes the assembled word and returns to `RXP_FILL`.

Flush forces both machines back to `TXU_EMPTY` and `RXP_FILL`.

Top module: `spi_word_packer`

## Requirements
- R1: For a word length of 4, 8, 16 or 32 bits, each FIFO word carries 32/length SPI words. Slot k sits in bits [k*length +: length]. Slot 0 is the first sent or received, so byte 0 of the FIFO word is bits 7:0. On transmit the slots are sent from slot 0 upward.
- R2: For any other length from 4 to 32, each FIFO word carries one SPI word in bits length-1:0. On receive, the bits above it are zero.
- R3: The engine word carries its first bit on the wire in bit length-1. With `cfg_lsb_first`=0 the engine word equals the data field. With `cfg_lsb_first`=1 it is the data field bit-reversed within the length.
- R4: `tx_wm_irq` is high exactly when `cfg_tx_wm` is nonzero and `tx_count` <= `cfg_tx_wm`. A value of 0 keeps it low.
- R5: `rx_count` gives the number of stored receive words. `rx_last` is high when the head word closed a command. `rx_last_bytes` is 0 when that word is full, or when the head is not a last word.
  - For packed lengths with n slots filled, `rx_last_bytes` is ceil(n*length/8), reported as 0 when that equals 4.
  - Otherwise it is 1 for lengths up to 8, 2 for lengths up to 16, and 0 above 16.
- R6: `eng_rx_ready` is low whenever `rx_count` > DEPTH-2, and during `RXP_COMMIT`. As a result `rx_count` never reaches DEPTH.
- R7: `rx_wm_irq` is high exactly when `cfg_rx_wm` is nonzero and `rx_count` >= `cfg_rx_wm`.
- R8: `rx_last_irq` is high while at least one last-marked word is stored in the receive FIFO.
- R9: One cycle of `flush` empties both FIFOs and drops the word held for transmit. It also discards a partly packed receive word, so none of its bits appear later.
- R10: A transmit write while `tx_full` is high is dropped. `tx_depth` equals DEPTH.
- R11: While `eng_tx_valid` is high and `eng_tx_ready` is low, the engine word holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty both FIFOs and the packing state |
| cfg_bpw | input | 6 | SPI word length, 4 to 32 |
| cfg_lsb_first | input | 1 | 1 selects least-significant bit first |
| cfg_tx_wm | input | CW | Transmit low-water level, 0 disables |
| cfg_rx_wm | input | CW | Receive high-water level, 0 disables |
| tx_wr_en | input | 1 | Host write strobe |
| tx_wr_data | input | 32 | Host write word |
| tx_full | output | 1 | Transmit FIFO full |
| tx_count | output | CW | Transmit FIFO occupancy |
| tx_depth | output | CW | Transmit FIFO depth |
| tx_wm_irq | output | 1 | Transmit low-water status |
| eng_tx_valid | output | 1 | Engine word available |
| eng_tx_ready | input | 1 | Engine takes the word |
| eng_tx_data | output | 32 | Engine word, first bit at length-1 |
| eng_rx_valid | input | 1 | Engine offers a received word |
| eng_rx_ready | output | 1 | Packer accepts |
| eng_rx_data | input | 32 | Received engine word |
| eng_rx_last | input | 1 | Word ends the command |
| rx_rd_en | input | 1 | Host read strobe |
| rx_rd_data | output | 32 | Head receive word |
| rx_count | output | CW | Receive FIFO occupancy |
| rx_last | output | 1 | Head word ends a command |
| rx_last_bytes | output | 2 | Valid bytes in head last word, 0 = four |
| rx_wm_irq | output | 1 | Receive high-water status |
| rx_last_irq | output | 1 | A last word is stored |

## Verification
A transmit write raises `tx_count` at the next rising edge. With the unpacker idle, the word leaves the FIFO one edge later, and the first engine word is valid after that edge. A receive word that completes a FIFO word is accepted at one edge, sits in `RXP_COMMIT` for the next, and shows in `rx_count` after that second edge. Flush acts at the next edge. The bench drives and samples only on falling edges and waits at least those edge counts before comparing. It sweeps every word length with both bit orders through both paths.

// File: rtl/spwp_pkg.sv
package spwp_pkg;

    localparam int FW = 32;

    typedef enum logic [0:0] {TXU_EMPTY, TXU_SEND} txu_state_t;
    typedef enum logic [0:0] {RXP_FILL, RXP_COMMIT} rxp_state_t;

    // SPI words per FIFO word: only exact divisors of the FIFO width pack
    function automatic logic [5:0] slots_of(input logic [5:0] bpw);
        logic [5:0] n;
        case (bpw)
            6'd4:    n = 6'd8;
            6'd8:    n = 6'd4;
            6'd16:   n = 6'd2;
            default: n = 6'd1;
        endcase
        return n;
    endfunction

    function automatic logic [31:0] field_mask(input logic [5:0] bpw);
        logic [32:0] t;
        t = (33'd1 << bpw) - 33'd1;
        return t[31:0];
    endfunction

    function automatic logic [31:0] bit_rev(input logic [31:0] d, input logic [5:0] bpw);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < FW; i++) begin
            if (i < int'(bpw)) r[i] = d[int'(bpw) - 1 - i];
        end
        return r;
    endfunction

    // valid bytes of a final word, 0 meaning all four
    function automatic logic [1:0] last_bytes(input logic [5:0] n, input logic [5:0] bpw);
        logic [11:0] bits;
        logic [11:0] b;
        logic [1:0]  r;
        if (slots_of(bpw) == 6'd1) begin
            r = (bpw <= 6'd8) ? 2'd1 : ((bpw <= 6'd16) ? 2'd2 : 2'd0);
        end else begin
            bits = {6'd0, n} * {6'd0, bpw};
            b    = (bits + 12'd7) >> 3;
            r    = (b == 12'd4) ? 2'd0 : b[1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/spwp_fifo.sv
module spwp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (pop_ok)  rptr <= step(rptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spwp_tx_unpack.sv
module spwp_tx_unpack
    import spwp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic [5:0]  bpw,
    input  logic        lsb_first,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_rdata,
    output logic        fifo_pop,
    output logic        eng_valid,
    input  logic        eng_ready,
    output logic [31:0] eng_data
);
    txu_state_t  st, st_n;
    logic [31:0] hold;
    logic [5:0]  slot;
    logic [5:0]  nslots;
    logic        last_slot;
    logic [11:0] shamt;
    logic [31:0] field;

    assign nslots    = slots_of(bpw);
    assign last_slot = (slot == nslots - 6'd1);
    assign shamt     = {6'd0, slot} * {6'd0, bpw};
    assign field     = (hold >> shamt) & field_mask(bpw);
    assign eng_data  = lsb_first ? bit_rev(field, bpw) : field;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TXU_EMPTY;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            slot <= '0;
        end else if (flush) begin
            slot <= '0;
        end else if (fifo_pop) begin
            hold <= fifo_rdata;
            slot <= '0;
        end else if (eng_valid && eng_ready) begin
            slot <= last_slot ? 6'd0 : slot + 6'd1;
        end
    end

    always_comb begin
        st_n      = st;
        fifo_pop  = 1'b0;
        eng_valid = 1'b0;
        unique case (st)
            TXU_EMPTY: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    st_n     = TXU_SEND;
                end
            end
            TXU_SEND: begin
                eng_valid = 1'b1;
                if (eng_ready && last_slot) st_n = TXU_EMPTY;
            end
        endcase
        if (flush) begin
            st_n     = TXU_EMPTY;
            fifo_pop = 1'b0;
        end
    end
endmodule

// File: rtl/spwp_rx_pack.sv
module spwp_rx_pack
    import spwp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [5:0]    bpw,
    input  logic          lsb_first,
    input  logic          eng_valid,
    output logic          eng_ready,
    input  logic [31:0]   eng_data,
    input  logic          eng_last,
    input  logic [CW-1:0] fifo_count,
    output logic          fifo_push,
    output logic [34:0]   fifo_wdata
);
    rxp_state_t  st, st_n;
    logic [31:0] acc;
    logic [5:0]  slot;
    logic        rec_last;
    logic [1:0]  rec_bytes;
    logic [5:0]  nslots;
    logic        accept, closing;
    logic [11:0] shamt;
    logic [31:0] field;
    logic        room;

    assign nslots     = slots_of(bpw);
    assign shamt      = {6'd0, slot} * {6'd0, bpw};
    assign field      = (lsb_first ? bit_rev(eng_data, bpw) : eng_data) & field_mask(bpw);
    assign room       = (fifo_count <= CW'(DEPTH - 2));
    assign accept     = eng_valid && eng_ready;
    assign closing    = accept && ((slot == nslots - 6'd1) || eng_last);
    assign fifo_wdata = {rec_last, rec_bytes, acc};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RXP_FILL;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            slot      <= '0;
            rec_last  <= 1'b0;
            rec_bytes <= '0;
        end else if (flush || fifo_push) begin
            acc      <= '0;
            slot     <= '0;
            rec_last <= 1'b0;
        end else if (accept) begin
            acc  <= acc | (field << shamt);
            slot <= slot + 6'd1;
            if (closing) begin
                rec_last  <= eng_last;
                rec_bytes <= last_bytes(slot + 6'd1, bpw);
            end
        end
    end

    always_comb begin
        st_n      = st;
        eng_ready = 1'b0;
        fifo_push = 1'b0;
        unique case (st)
            RXP_FILL: begin
                eng_ready = room;
                if (closing) st_n = RXP_COMMIT;
            end
            RXP_COMMIT: begin
                fifo_push = 1'b1;
                st_n      = RXP_FILL;
            end
        endcase
        if (flush) begin
            st_n      = RXP_FILL;
            fifo_push = 1'b0;
        end
    end
endmodule

// File: rtl/spi_word_packer.sv
module spi_word_packer #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [5:0]    cfg_bpw,
    input  logic          cfg_lsb_first,
    input  logic [CW-1:0] cfg_tx_wm,
    input  logic [CW-1:0] cfg_rx_wm,
    input  logic          tx_wr_en,
    input  logic [31:0]   tx_wr_data,
    output logic          tx_full,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] tx_depth,
    output logic          tx_wm_irq,
    output logic          eng_tx_valid,
    input  logic          eng_tx_ready,
    output logic [31:0]   eng_tx_data,
    input  logic          eng_rx_valid,
    output logic          eng_rx_ready,
    input  logic [31:0]   eng_rx_data,
    input  logic          eng_rx_last,
    input  logic          rx_rd_en,
    output logic [31:0]   rx_rd_data,
    output logic [CW-1:0] rx_count,
    output logic          rx_last,
    output logic [1:0]    rx_last_bytes,
    output logic          rx_wm_irq,
    output logic          rx_last_irq
);
    logic          txf_empty, txf_pop;
    logic [31:0]   txf_rdata;
    logic          rxf_push, rxf_full, rxf_empty, rx_pop;
    logic [34:0]   rxf_wdata, rxf_rdata;
    logic [CW-1:0] last_cnt;

    assign tx_depth = CW'(DEPTH);

    spwp_fifo #(.W(32), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(tx_wr_en), .wdata(tx_wr_data),
        .pop(txf_pop), .rdata(txf_rdata),
        .count(tx_count), .full(tx_full), .empty(txf_empty)
    );

    spwp_tx_unpack u_unpack (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .bpw(cfg_bpw), .lsb_first(cfg_lsb_first),
        .fifo_empty(txf_empty), .fifo_rdata(txf_rdata), .fifo_pop(txf_pop),
        .eng_valid(eng_tx_valid), .eng_ready(eng_tx_ready), .eng_data(eng_tx_data)
    );

    spwp_rx_pack #(.DEPTH(DEPTH)) u_pack (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .bpw(cfg_bpw), .lsb_first(cfg_lsb_first),
        .eng_valid(eng_rx_valid), .eng_ready(eng_rx_ready),
        .eng_data(eng_rx_data), .eng_last(eng_rx_last),
        .fifo_count(rx_count), .fifo_push(rxf_push), .fifo_wdata(rxf_wdata)
    );

    spwp_fifo #(.W(35), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rxf_push), .wdata(rxf_wdata),
        .pop(rx_pop), .rdata(rxf_rdata),
        .count(rx_count), .full(rxf_full), .empty(rxf_empty)
    );

    assign rx_pop        = rx_rd_en && !rxf_empty;
    assign rx_rd_data    = rxf_rdata[31:0];
    assign rx_last       = !rxf_empty && rxf_rdata[34];
    assign rx_last_bytes = rx_last ? rxf_rdata[33:32] : 2'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cnt <= '0;
        end else if (flush) begin
            last_cnt <= '0;
        end else begin
            unique case ({rxf_push && rxf_wdata[34], rx_pop && rx_last})
                2'b10:   last_cnt <= last_cnt + CW'(1);
                2'b01:   last_cnt <= last_cnt - CW'(1);
                default: last_cnt <= last_cnt;
            endcase
        end
    end

    assign tx_wm_irq   = (cfg_tx_wm != '0) && (tx_count <= cfg_tx_wm);
    assign rx_wm_irq   = (cfg_rx_wm != '0) && (rx_count >= cfg_rx_wm);
    assign rx_last_irq = (last_cnt != '0);
endmodule

// File: rtl/spwp_chk.sv
module spwp_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic [CW-1:0] cfg_tx_wm,
    input logic [CW-1:0] tx_count,
    input logic          tx_wm_irq,
    input logic          eng_tx_valid,
    input logic          eng_tx_ready,
    input logic [31:0]   eng_tx_data,
    input logic [CW-1:0] rx_count,
    input logic          rx_last,
    input logic [1:0]    rx_last_bytes,
    input logic          rx_last_irq
);
    // R6
    rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count < CW'(DEPTH));

    // R10
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_count == '0 && rx_count == '0 && !eng_tx_valid && !rx_last_irq));

    // R11
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_valid && !eng_tx_ready && !flush) |=> (eng_tx_valid && $stable(eng_tx_data)));

    // R5
    last_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_last_bytes != 2'd0) |-> rx_last);

    // R4
    tx_wm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_tx_wm == '0) |-> !tx_wm_irq);
endmodule

bind spi_word_packer spwp_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/spi_word_packer_test.sv
`timescale 1ns/1ps
module spi_word_packer_test;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic [5:0]    cfg_bpw = 6'd8;
    logic          cfg_lsb_first = 1'b0;
    logic [CW-1:0] cfg_tx_wm = '0;
    logic [CW-1:0] cfg_rx_wm = '0;
    logic          tx_wr_en = 1'b0;
    logic [31:0]   tx_wr_data = '0;
    logic          tx_full;
    logic [CW-1:0] tx_count, tx_depth, rx_count;
    logic          tx_wm_irq, eng_tx_valid, eng_rx_ready, rx_last, rx_wm_irq, rx_last_irq;
    logic          eng_tx_ready = 1'b0;
    logic [31:0]   eng_tx_data, rx_rd_data;
    logic          eng_rx_valid = 1'b0;
    logic [31:0]   eng_rx_data = '0;
    logic          eng_rx_last = 1'b0;
    logic          rx_rd_en = 1'b0;
    logic [1:0]    rx_last_bytes;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    spi_word_packer #(.DEPTH(DEPTH)) uut (.*);

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int b_slots(input int b);
        return (32 % b == 0) ? 32 / b : 1;
    endfunction

    function automatic logic [31:0] b_mask(input int b);
        return (b == 32) ? 32'hFFFF_FFFF : ((32'd1 << b) - 32'd1);
    endfunction

    function automatic logic [31:0] b_rev(input logic [31:0] d, input int b);
        logic [31:0] r = '0;
        for (int i = 0; i < b; i++) r[i] = d[b - 1 - i];
        return r;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tx_write(input logic [31:0] d);
        tx_wr_en = 1'b1;
        tx_wr_data = d;
        @(posedge clk);
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic rx_push(input logic [31:0] d, input logic last);
        eng_rx_valid = 1'b1;
        eng_rx_data = d;
        eng_rx_last = last;
        while (!eng_rx_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        eng_rx_valid = 1'b0;
        eng_rx_last = 1'b0;
    endtask

    task automatic rx_read(input logic [31:0] d, input logic last, input logic [1:0] nb, input string req);
        chk(req, rx_rd_data, d);
        chk(req, {31'd0, rx_last}, {31'd0, last});
        chk("R5", {30'd0, rx_last_bytes}, {30'd0, nb});
        rx_rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rx_rd_en = 1'b0;
    endtask

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // reset state
        chk("R10", 32'(tx_count), 32'd0);
        chk("R5", 32'(rx_count), 32'd0);
        chk("R11", {31'd0, eng_tx_valid}, 32'd0);
        chk("R8", {31'd0, rx_last_irq}, 32'd0);
        chk("R10", 32'(tx_depth), 32'(DEPTH));
        chk("R6", {31'd0, eng_rx_ready}, 32'd1);

        // transmit sweep over every length and both orders
        for (int b = 4; b <= 32; b++) begin
            for (int l = 0; l < 2; l++) begin
                logic [31:0] w [2];
                int ns;
                int idx;
                string tag;
                ns = b_slots(b);
                tag = (l == 1) ? "R3" : ((ns > 1) ? "R1" : "R2");
                cfg_bpw = 6'(b);
                cfg_lsb_first = l[0];
                w[0] = 32'hA5C3_1E69 ^ (32'h0101_0101 * 32'(b));
                w[1] = {w[0][15:0], ~w[0][31:16]};
                tx_write(w[0]);
                tx_write(w[1]);
                idx = 0;
                eng_tx_ready = 1'b1;
                while (idx < 2 * ns) begin
                    if (eng_tx_valid) begin
                        logic [31:0] f;
                        f = (w[idx / ns] >> ((idx % ns) * b)) & b_mask(b);
                        chk(tag, eng_tx_data, (l == 1) ? b_rev(f, b) : f);
                        idx++;
                    end
                    @(negedge clk);
                end
                eng_tx_ready = 1'b0;
                chk(tag, {31'd0, eng_tx_valid}, 32'd0);
            end
        end

        // receive sweep over every length and both orders
        for (int b = 4; b <= 32; b++) begin
            for (int l = 0; l < 2; l++) begin
                int ns;
                int nw;
                logic [31:0] e0, e1, v;
                logic [1:0] nb;
                string tag;
                ns = b_slots(b);
                nw = (ns > 1) ? ns + 1 : 2;
                tag = (l == 1) ? "R3" : ((ns > 1) ? "R1" : "R2");
                cfg_bpw = 6'(b);
                cfg_lsb_first = l[0];
                e0 = '0;
                e1 = '0;
                for (int i = 0; i < nw; i++) begin
                    v = (32'h9E37_79B9 * 32'(i + 1) + 32'(b * 7 + l)) & b_mask(b);
                    if (ns > 1) begin
                        if (i < ns) e0 = e0 | (v << (i * b));
                        else        e1 = v;
                    end else begin
                        if (i == 0) e0 = v;
                        else        e1 = v;
                    end
                    rx_push((l == 1) ? b_rev(v, b) : v, i == nw - 1);
                end
                if (ns > 1) nb = 2'((b + 7) / 8);
                else        nb = (b <= 8) ? 2'd1 : ((b <= 16) ? 2'd2 : 2'd0);
                idle(3);
                chk("R5", 32'(rx_count), 32'd2);
                chk("R8", {31'd0, rx_last_irq}, 32'd1);
                rx_read(e0, 1'b0, 2'd0, tag);
                rx_read(e1, 1'b1, nb, tag);
                chk("R8", {31'd0, rx_last_irq}, 32'd0);
            end
        end

        // transmit low-water mark and full
        cfg_bpw = 6'd32;
        cfg_lsb_first = 1'b0;
        cfg_tx_wm = CW'(3);
        tx_write(32'h1111_1111);
        idle(2);
        chk("R4", 32'(tx_count), 32'd0);
        chk("R4", {31'd0, tx_wm_irq}, 32'd1);
        for (int i = 0; i < 3; i++) tx_write(32'(i));
        chk("R4", {31'd0, tx_wm_irq}, 32'd1);
        tx_write(32'h5);
        chk("R4", {31'd0, tx_wm_irq}, 32'd0);
        for (int i = 0; i < 6; i++) tx_write(32'h77 + 32'(i));
        chk("R10", 32'(tx_count), 32'(DEPTH));
        chk("R10", {31'd0, tx_full}, 32'd1);
        chk("R11", eng_tx_data, 32'h1111_1111);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R9", 32'(tx_count), 32'd0);
        chk("R9", {31'd0, eng_tx_valid}, 32'd0);
        cfg_tx_wm = '0;
        idle(1);
        chk("R4", {31'd0, tx_wm_irq}, 32'd0);

        // receive high-water mark and back-pressure
        cfg_rx_wm = CW'(2);
        rx_push(32'hC0DE_0001, 1'b0);
        idle(2);
        chk("R7", 32'(rx_count), 32'd1);
        chk("R7", {31'd0, rx_wm_irq}, 32'd0);
        rx_push(32'hC0DE_0002, 1'b0);
        idle(2);
        chk("R7", {31'd0, rx_wm_irq}, 32'd1);
        for (int i = 0; i < 5; i++) rx_push(32'h100 + 32'(i), 1'b0);
        idle(2);
        chk("R6", 32'(rx_count), 32'(DEPTH - 1));
        chk("R6", {31'd0, eng_rx_ready}, 32'd0);
        rx_read(32'hC0DE_0001, 1'b0, 2'd0, "R6");
        chk("R6", {31'd0, eng_rx_ready}, 32'd1);

        // flush drops a partly packed word
        cfg_bpw = 6'd8;
        rx_push(32'hEE, 1'b0);
        rx_push(32'hDD, 1'b0);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R9", 32'(rx_count), 32'd0);
        rx_push(32'h11, 1'b0);
        rx_push(32'h22, 1'b0);
        rx_push(32'h33, 1'b0);
        rx_push(32'h44, 1'b1);
        idle(3);
        rx_read(32'h4433_2211, 1'b1, 2'd0, "R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule